// File: doc/BRIEF.md
# Pipelined Multiplier with Issue Interlock

This block is a four-stage integer multiplier that runs beside the single-cycle execute and memory stages of a five-stage in-order core. A multiply leaves decode and enters the first multiplier stage. Its product reaches the last stage four cycles later. That last stage is a register that feeds writeback directly. A new, independent multiply may start every cycle, so several multiplies can be in flight at once.

Because the multiplier is a parallel path of a different length, the block also decides whether the instruction now in decode has to wait. It compares the decode instruction with the valid bit and destination tag held in each multiplier stage and raises a stall request. The surrounding pipeline ORs that request with its own stall logic.

The request covers three hazards:
- a source operand that is still being computed;
- two results competing for the single register-file write port in the same cycle;
- a younger single-cycle instruction that would write a register before an older multiply to the same register does.

Top module: `mul_issue_lock`

## Requirements
- R1: While reset is asserted, every multiplier stage is emptied. During and after reset, `wb_valid` is 0 and `mul_stall` is 0 until a multiply is accepted.
- R2: `wb_product` equals the low 32 bits of the signed product of the two operands presented with the multiply. The most negative value times -1 gives 0x80000000.
- R3: A multiply is accepted in a cycle when `dec_valid`=1, `dec_is_mul`=1, `mul_stall`=0 and `base_stall`=0. Exactly four cycles after that cycle, `wb_valid` is 1 and `wb_tag` carries that multiply's `dec_dst`.
- R4: Multiplies may be accepted in consecutive cycles without stalling one another when their destinations differ and none reads another's result. Their products then appear in consecutive cycles, in issue order.
- R5: While `dec_valid`=1, `mul_stall` is 1 if `dec_src_a` or `dec_src_b` equals the destination of a multiply in its first, second or third stage. A multiply in its fourth stage causes no such stall.
- R6: While `dec_valid`=1, `mul_stall` is 1 if the decode instruction is not a multiply, has `dec_dst_en`=1, and a multiply occupies the second stage. A decode multiply, or an instruction with `dec_dst_en`=0, is not stalled for this reason.
- R7: While `dec_valid`=1 and `dec_dst_en`=1, `mul_stall` is 1 if `dec_dst` equals the destination of a multiply in the first or second stage. A multiply in the third stage causes no such stall.
- R8: `mul_stall` is 0 whenever `dec_valid`=0. A multiply presented while `base_stall`=1 is not accepted and produces no result.
- R9: An instruction that reads the destination of the multiply accepted in the cycle just before it sees `mul_stall`=1 for exactly three cycles and is accepted in the fourth.
- R10: Four cycles after a cycle in which no multiply was accepted, `wb_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_valid | input | 1 | Decode stage holds an instruction |
| dec_is_mul | input | 1 | Decode instruction is a multiply |
| dec_src_a | input | TAG_W | First source register number |
| dec_src_b | input | TAG_W | Second source register number |
| dec_dst_en | input | 1 | Decode instruction writes a register |
| dec_dst | input | TAG_W | Destination register number |
| dec_opnd_a | input | XLEN | First multiply operand (already bypassed) |
| dec_opnd_b | input | XLEN | Second multiply operand (already bypassed) |
| base_stall | input | 1 | Stall from the rest of the pipeline |
| mul_stall | output | 1 | Stall request from the multiplier interlock |
| wb_valid | output | 1 | Fourth stage holds a finished multiply |
| wb_tag | output | TAG_W | Destination of the finished multiply |
| wb_product | output | XLEN | Low XLEN bits of the product |

## Verification
The properties assume that a multiply always writes a destination, so the block ignores `dec_dst_en` for multiplies. The bench therefore drives it high on every multiply. They also assume that `base_stall` alone decides whether the rest of the pipeline holds decode. The stimulus never lets a multiply count as accepted while that input is high.

The bench keeps each instruction steady in decode until it is accepted, as a real decode latch would. Its dependency cases place a reader or writer exactly one, two and three cycles behind a multiply. This exposes both edges of each hazard window.

// File: rtl/mul_lock_pkg.sv
package mul_lock_pkg;
  // Number of multiplier stages between decode and writeback.
  localparam int MUL_STAGES = 4;
  // Last stage whose destination is not yet readable through bypass.
  localparam int RAW_LAST   = 2;
  // Stage whose writeback coincides with a single-cycle instruction now in decode.
  localparam int PORT_STAGE = 1;
  // Last stage that would write back after a single-cycle instruction now in decode.
  localparam int ORDER_LAST = 1;
endpackage

// File: rtl/mul_tag_pipe.sv
module mul_tag_pipe
  import mul_lock_pkg::*;
#(
  parameter int TAG_W = 5
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               in_valid,
  input  logic [TAG_W-1:0]                   in_tag,
  output logic [MUL_STAGES-1:0]              stg_vld,
  output logic [MUL_STAGES-1:0][TAG_W-1:0]   stg_tag
);
  always_ff @(posedge clk) begin
    if (rst) stg_vld[0] <= 1'b0;
    else     stg_vld[0] <= in_valid;
    stg_tag[0] <= in_tag;
  end

  for (genvar k = 1; k < MUL_STAGES; k++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg_vld[k] <= 1'b0;
      else     stg_vld[k] <= stg_vld[k-1];
      stg_tag[k] <= stg_tag[k-1];
    end
  end
endmodule

// File: rtl/mul_datapath.sv
module mul_datapath #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            in_en,
  input  logic [XLEN-1:0] opnd_a,
  input  logic [XLEN-1:0] opnd_b,
  output logic [XLEN-1:0] product
);
  localparam int HALF = XLEN / 2;

  // The low XLEN bits of a signed product equal those of the unsigned one,
  // so the split works on raw bit patterns.
  logic [XLEN-1:0] s0_a, s0_b;
  logic [XLEN-1:0] s1_ll;
  logic [HALF-1:0] s1_lh, s1_hl;
  logic [XLEN-1:0] s2_ll;
  logic [HALF-1:0] s2_cross;

  logic [XLEN-1:0] full_ll, full_lh, full_hl;

  always_comb begin
    full_ll = XLEN'(s0_a[HALF-1:0]) * XLEN'(s0_b[HALF-1:0]);
    full_lh = XLEN'(s0_a[HALF-1:0]) * XLEN'(s0_b[XLEN-1:HALF]);
    full_hl = XLEN'(s0_a[XLEN-1:HALF]) * XLEN'(s0_b[HALF-1:0]);
  end

  always_ff @(posedge clk) begin
    if (in_en) begin
      s0_a <= opnd_a;
      s0_b <= opnd_b;
    end
    s1_ll    <= full_ll;
    s1_lh    <= full_lh[HALF-1:0];
    s1_hl    <= full_hl[HALF-1:0];
    s2_ll    <= s1_ll;
    s2_cross <= s1_lh + s1_hl;
    product  <= s2_ll + {s2_cross, {HALF{1'b0}}};
  end
endmodule

// File: rtl/mul_hazard_unit.sv
module mul_hazard_unit
  import mul_lock_pkg::*;
#(
  parameter int TAG_W = 5
) (
  input  logic                               dec_valid,
  input  logic                               dec_is_mul,
  input  logic [TAG_W-1:0]                   dec_src_a,
  input  logic [TAG_W-1:0]                   dec_src_b,
  input  logic                               dec_dst_en,
  input  logic [TAG_W-1:0]                   dec_dst,
  input  logic [MUL_STAGES-1:0]              stg_vld,
  input  logic [MUL_STAGES-1:0][TAG_W-1:0]   stg_tag,
  output logic                               stall
);
  logic [MUL_STAGES-1:0] raw_hit;
  logic [MUL_STAGES-1:0] order_hit;
  logic                  port_hit;

  for (genvar k = 0; k < MUL_STAGES; k++) begin : g_cmp
    if (k <= RAW_LAST) begin : g_raw
      assign raw_hit[k] = stg_vld[k] &&
                          ((stg_tag[k] == dec_src_a) || (stg_tag[k] == dec_src_b));
    end else begin : g_noraw
      assign raw_hit[k] = 1'b0;
    end
    if (k <= ORDER_LAST) begin : g_ord
      assign order_hit[k] = stg_vld[k] && dec_dst_en && (stg_tag[k] == dec_dst);
    end else begin : g_noord
      assign order_hit[k] = 1'b0;
    end
  end

  assign port_hit = stg_vld[PORT_STAGE] && dec_dst_en && !dec_is_mul;
  assign stall    = dec_valid && ((|raw_hit) || (|order_hit) || port_hit);
endmodule

// File: rtl/mul_issue_lock.sv
module mul_issue_lock
  import mul_lock_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int TAG_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dec_valid,
  input  logic             dec_is_mul,
  input  logic [TAG_W-1:0] dec_src_a,
  input  logic [TAG_W-1:0] dec_src_b,
  input  logic             dec_dst_en,
  input  logic [TAG_W-1:0] dec_dst,
  input  logic [XLEN-1:0]  dec_opnd_a,
  input  logic [XLEN-1:0]  dec_opnd_b,
  input  logic             base_stall,
  output logic             mul_stall,
  output logic             wb_valid,
  output logic [TAG_W-1:0] wb_tag,
  output logic [XLEN-1:0]  wb_product
);
  logic                             take_mul;
  logic [MUL_STAGES-1:0]            stg_vld;
  logic [MUL_STAGES-1:0][TAG_W-1:0] stg_tag;

  assign take_mul = dec_valid && dec_is_mul && !mul_stall && !base_stall;

  mul_tag_pipe #(.TAG_W(TAG_W)) u_tags (
    .clk      (clk),
    .rst      (rst),
    .in_valid (take_mul),
    .in_tag   (dec_dst),
    .stg_vld  (stg_vld),
    .stg_tag  (stg_tag)
  );

  mul_datapath #(.XLEN(XLEN)) u_dp (
    .clk     (clk),
    .in_en   (take_mul),
    .opnd_a  (dec_opnd_a),
    .opnd_b  (dec_opnd_b),
    .product (wb_product)
  );

  mul_hazard_unit #(.TAG_W(TAG_W)) u_hz (
    .dec_valid  (dec_valid),
    .dec_is_mul (dec_is_mul),
    .dec_src_a  (dec_src_a),
    .dec_src_b  (dec_src_b),
    .dec_dst_en (dec_dst_en),
    .dec_dst    (dec_dst),
    .stg_vld    (stg_vld),
    .stg_tag    (stg_tag),
    .stall      (mul_stall)
  );

  assign wb_valid = stg_vld[MUL_STAGES-1];
  assign wb_tag   = stg_tag[MUL_STAGES-1];
endmodule

// File: rtl/mul_issue_lock_chk.sv
module mul_issue_lock_chk #(
  parameter int XLEN  = 32,
  parameter int TAG_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             dec_valid,
  input logic             dec_is_mul,
  input logic [TAG_W-1:0] dec_src_a,
  input logic [TAG_W-1:0] dec_src_b,
  input logic             dec_dst_en,
  input logic [TAG_W-1:0] dec_dst,
  input logic             base_stall,
  input logic             mul_stall,
  input logic             wb_valid,
  input logic [TAG_W-1:0] wb_tag
);
  logic acc;
  assign acc = dec_valid && dec_is_mul && !mul_stall && !base_stall;

  p_latency_r3: assert property (@(posedge clk) disable iff (rst)
    acc |-> ##4 (wb_valid && wb_tag == $past(dec_dst, 4)));

  p_bubble_r10: assert property (@(posedge clk) disable iff (rst)
    !acc |-> ##4 !wb_valid);

  p_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !dec_valid |-> !mul_stall);

  p_raw_r5: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && !$past(rst) && $past(acc) &&
     (dec_src_a == $past(dec_dst) || dec_src_b == $past(dec_dst))) |-> mul_stall);

  p_port_r6: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && !dec_is_mul && dec_dst_en && !$past(rst) && !$past(rst, 2) &&
     $past(acc, 2)) |-> mul_stall);

  p_order_r7: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && dec_dst_en && !$past(rst) && $past(acc) &&
     dec_dst == $past(dec_dst)) |-> mul_stall);
endmodule

bind mul_issue_lock mul_issue_lock_chk #(.XLEN(XLEN), .TAG_W(TAG_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .dec_valid  (dec_valid),
  .dec_is_mul (dec_is_mul),
  .dec_src_a  (dec_src_a),
  .dec_src_b  (dec_src_b),
  .dec_dst_en (dec_dst_en),
  .dec_dst    (dec_dst),
  .base_stall (base_stall),
  .mul_stall  (mul_stall),
  .wb_valid   (wb_valid),
  .wb_tag     (wb_tag)
);

// File: tb/sim_mul_issue_lock.sv
`timescale 1ns/1ps
module sim_mul_issue_lock;
  localparam int XLEN  = 32;
  localparam int TAG_W = 5;

  logic             clk = 1'b0;
  logic             rst;
  logic             dec_valid, dec_is_mul, dec_dst_en, base_stall;
  logic [TAG_W-1:0] dec_src_a, dec_src_b, dec_dst;
  logic [XLEN-1:0]  dec_opnd_a, dec_opnd_b;
  logic             mul_stall, wb_valid;
  logic [TAG_W-1:0] wb_tag;
  logic [XLEN-1:0]  wb_product;

  always #2.5 clk = ~clk;

  mul_issue_lock #(.XLEN(XLEN), .TAG_W(TAG_W)) u0 (
    .clk(clk), .rst(rst), .dec_valid(dec_valid), .dec_is_mul(dec_is_mul),
    .dec_src_a(dec_src_a), .dec_src_b(dec_src_b), .dec_dst_en(dec_dst_en),
    .dec_dst(dec_dst), .dec_opnd_a(dec_opnd_a), .dec_opnd_b(dec_opnd_b),
    .base_stall(base_stall), .mul_stall(mul_stall), .wb_valid(wb_valid),
    .wb_tag(wb_tag), .wb_product(wb_product)
  );

  typedef struct {
    int          tag;
    logic [31:0] prod;
    int          age;
  } flight_t;

  flight_t fl[$];
  int n_chk = 0;
  int n_bad = 0;
  int wb_seen = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_mul(input logic [31:0] a, input logic [31:0] b);
    longint p;
    p = longint'($signed(a)) * longint'($signed(b));
    return p[31:0];
  endfunction

  // One clock: drive at negedge, compare against the model, advance the model.
  task automatic tick(input bit v, input bit m, input int sa, input int sb,
                      input bit de, input int d, input logic [31:0] a,
                      input logic [31:0] b, input bit bs,
                      output bit acc, output bit st);
    bit raw, port, ord, exp_st, got;
    int wi;
    string lbl;
    @(negedge clk);
    dec_valid = v; dec_is_mul = m; dec_src_a = TAG_W'(sa); dec_src_b = TAG_W'(sb);
    dec_dst_en = de; dec_dst = TAG_W'(d); dec_opnd_a = a; dec_opnd_b = b;
    base_stall = bs;
    #1;
    raw = 0; port = 0; ord = 0; wi = -1;
    foreach (fl[i]) begin
      int stg;
      stg = fl[i].age - 1;
      if (v) begin
        if (stg <= 2 && (fl[i].tag == sa || fl[i].tag == sb)) raw = 1;
        if (stg == 1 && de && !m) port = 1;
        if (stg <= 1 && de && fl[i].tag == d) ord = 1;
      end
      if (fl[i].age == 4) wi = i;
    end
    exp_st = raw | port | ord;
    lbl = raw ? "R5" : (port ? "R6" : (ord ? "R7" : "R8"));
    chk(mul_stall === exp_st, lbl, "mul_stall", longint'(mul_stall), longint'(exp_st));
    if (wi >= 0) begin
      got = (wb_valid === 1'b1);
      chk(got, "R3", "wb_valid", longint'(wb_valid), 1);
      chk(int'(wb_tag) == fl[wi].tag, "R3", "wb_tag", longint'(wb_tag), longint'(fl[wi].tag));
      chk(wb_product === fl[wi].prod, "R2", "wb_product", longint'(wb_product),
          longint'(fl[wi].prod));
    end else begin
      chk(wb_valid === 1'b0, "R10", "wb_valid", longint'(wb_valid), 0);
    end
    if (wb_valid === 1'b1) wb_seen++;
    st  = exp_st;
    acc = v && m && !exp_st && !bs;
    @(posedge clk);
    foreach (fl[i]) fl[i].age++;
    while (fl.size() > 0 && fl[0].age > 4) void'(fl.pop_front());
    if (acc) fl.push_back('{tag: d, prod: ref_mul(a, b), age: 1});
  endtask

  task automatic idle(input int n);
    bit acc, st;
    for (int i = 0; i < n; i++) tick(0, 0, 0, 0, 0, 0, 0, 0, 0, acc, st);
  endtask

  // Hold an instruction in decode until accepted; returns stalled cycles.
  task automatic issue(input bit m, input int sa, input int sb, input bit de,
                       input int d, input logic [31:0] a, input logic [31:0] b,
                       output int nst);
    bit acc, st;
    nst = 0;
    for (int i = 0; i < 20; i++) begin
      tick(1, m, sa, sb, de, d, a, b, 0, acc, st);
      if (!st) break;
      nst++;
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int ns, base;
    bit acc, st;
    rst = 1; dec_valid = 0; dec_is_mul = 0; dec_src_a = 0; dec_src_b = 0;
    dec_dst_en = 0; dec_dst = 0; dec_opnd_a = 0; dec_opnd_b = 0; base_stall = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(wb_valid === 1'b0, "R1", "wb_valid in reset", longint'(wb_valid), 0);
    chk(mul_stall === 1'b0, "R1", "mul_stall in reset", longint'(mul_stall), 0);
    rst = 0;
    idle(2);

    // R4: burst of independent multiplies
    base = wb_seen;
    for (int i = 1; i <= 6; i++) begin
      issue(1, 30, 31, 1, i, 32'(i * 1000 + 7), 32'(-i), ns);
      chk(ns == 0, "R4", "burst stall", ns, 0);
    end
    idle(6);
    chk(wb_seen - base == 6, "R4", "burst products", wb_seen - base, 6);

    // R9: reader right behind a multiply
    issue(1, 30, 31, 1, 7, 32'd12345, 32'd678, ns);
    issue(0, 7, 30, 1, 20, 0, 0, ns);
    chk(ns == 3, "R9", "dependent stall cycles", ns, 3);
    idle(5);

    // R5: reader arriving when multiply is in its fourth stage
    issue(1, 30, 31, 1, 16, 32'd5, 32'd9, ns);
    idle(3);
    issue(0, 16, 16, 1, 21, 0, 0, ns);
    chk(ns == 0, "R5", "no stall at fourth stage", ns, 0);
    idle(5);

    // R6: write-port contention
    issue(1, 30, 31, 1, 8, 32'd3, 32'd4, ns);
    idle(1);
    issue(0, 30, 31, 1, 9, 0, 0, ns);
    chk(ns == 1, "R6", "port stall", ns, 1);
    idle(5);
    issue(1, 30, 31, 1, 12, 32'd3, 32'd4, ns);
    idle(1);
    issue(0, 30, 31, 0, 22, 0, 0, ns);
    chk(ns == 0, "R6", "no-dest no stall", ns, 0);
    idle(5);
    issue(1, 30, 31, 1, 13, 32'd3, 32'd4, ns);
    idle(1);
    issue(1, 30, 31, 1, 14, 32'd6, 32'd7, ns);
    chk(ns == 0, "R6", "multiply no port stall", ns, 0);
    idle(6);

    // R7: write ordering
    issue(1, 30, 31, 1, 10, 32'd11, 32'd13, ns);
    issue(0, 30, 31, 1, 10, 0, 0, ns);
    chk(ns == 2, "R7", "order stall", ns, 2);
    idle(5);
    issue(1, 30, 31, 1, 11, 32'd11, 32'd13, ns);
    idle(2);
    issue(0, 30, 31, 1, 11, 0, 0, ns);
    chk(ns == 0, "R7", "no stall at third stage", ns, 0);
    idle(5);
    issue(1, 30, 31, 1, 15, 32'd2, 32'd2, ns);
    issue(1, 30, 31, 1, 15, 32'd3, 32'd3, ns);
    chk(ns == 2, "R7", "mul-mul same dest", ns, 2);
    idle(6);

    // R8: base stall blocks acceptance; idle decode never stalls
    base = wb_seen;
    tick(1, 1, 30, 31, 1, 17, 32'd99, 32'd99, 1, acc, st);
    chk(acc == 0, "R8", "accepted under base stall", acc, 0);
    idle(6);
    chk(wb_seen == base, "R8", "product after base stall", wb_seen - base, 0);
    issue(1, 30, 31, 1, 18, 32'd1, 32'd1, ns);
    tick(0, 0, 18, 18, 1, 18, 0, 0, 0, acc, st);
    chk(st == 0, "R8", "idle decode stall", st, 0);
    idle(6);

    // R2: signed corner operands
    issue(1, 30, 31, 1, 1, 32'h8000_0000, 32'hFFFF_FFFF, ns);
    issue(1, 30, 31, 1, 2, 32'h7FFF_FFFF, 32'h7FFF_FFFF, ns);
    issue(1, 30, 31, 1, 3, 32'hFFFF_FFFD, 32'd5, ns);
    issue(1, 30, 31, 1, 4, 32'd0, 32'hDEAD_BEEF, ns);
    issue(1, 30, 31, 1, 5, 32'hFFFF_FFFF, 32'hFFFF_FFFF, ns);
    idle(6);

    // Mixed random traffic
    for (int i = 0; i < 300; i++) begin
      int r;
      r = int'($urandom_range(0, 9));
      if (r < 2) idle(1);
      else if (r == 2)
        tick(1, 1, int'($urandom_range(0, 7)), 30, 1, int'($urandom_range(0, 7)),
             $urandom, $urandom, 1, acc, st);
      else
        issue(r < 7, int'($urandom_range(0, 7)), int'($urandom_range(0, 7)),
              (r < 7) || r[0], int'($urandom_range(0, 7)), $urandom, $urandom, ns);
    end
    idle(6);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule